// File: doc/BRIEF.md
# Run-time Framed Asynchronous Serial Transceiver

This block turns bytes into asynchronous serial characters and back again. The frame is chosen at run time and can be changed between characters. The data length is five to eight bits. A parity bit can be added, with odd or even sense, followed by one or two stop bits. Both directions share a single oversampling tick, which a divider outside the block supplies at sixteen ticks per bit time. Bytes enter the transmitter through a valid/ready handshake. Received characters leave as a single-cycle valid pulse that carries the data and two error flags for that character.

The transmitter can be held back by a clear-to-send input from the far end. A two-wire setting removes that gate, for links that carry only the data lines. A busy output covers the whole time a character is on the line. Software can poll it before it changes the bit rate or the frame format. The frame settings are captured when a character starts, so a change applies from the next character.

Top module: `serial_frame_xcvr`

## Requirements
- R1: `cfg_len` selects the data length with a reversed code: 00 gives 8 bits, 01 gives 7, 10 gives 6 and 11 gives 5. Data bits go out least significant bit first, and unused upper bits of `tx_data` are not sent.
- R2: When `cfg_par_en` is 1, a parity bit follows the data. `cfg_par_odd`=1 makes the data bits plus the parity bit hold an odd number of ones, and 0 makes that count even.
- R3: `cfg_stop` code 01 sends two stop bits (high). Codes 00, 10 and 11 send one stop bit. The receiver checks the same number of stop bits.
- R4: When `cfg_two_wire` is 0, `tx_ready` is high only while `cts` has been high for the last two clock edges and the transmitter is idle. When `cfg_two_wire` is 1, `cts` has no effect.
- R5: `txd` idles high. It drives the start bit (low) from the clock cycle after a handshake. Every bit lasts exactly 16 `baud_tick` pulses, and a tick on the handshake edge is not counted.
- R6: `tx_busy` is high from the cycle the start bit appears until the last stop bit has lasted its 16 ticks. `tx_ready` is low while `tx_busy` is high.
- R7: The receiver confirms a start bit by sampling it at mid-bit. A start that is high again at mid-bit is dropped without a result. Each later bit is sampled 16 ticks after the previous sample.
- R8: `rx_par_err` is set with a character whose parity bit does not match the configured sense. It is always 0 when parity is disabled.
- R9: `rx_frm_err` is set with a character if any of its configured stop bits is sampled low.
- R10: `rx_valid` is a one-cycle pulse at the last stop-bit sample. `rx_data` holds the character right-aligned, and unused upper bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Oversampling tick, 16 per bit time |
| cfg_len | input | 2 | Data length code (00=8, 01=7, 10=6, 11=5) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 odd parity, 0 even parity |
| cfg_stop | input | 2 | Stop-bit code (01 two, otherwise one) |
| cfg_two_wire | input | 1 | 1 ignores `cts` |
| cts | input | 1 | Far end ready to receive, active high, asynchronous |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Transmitter accepts a byte this cycle |
| txd | output | 1 | Serial output |
| tx_busy | output | 1 | Character on the line |
| rxd | input | 1 | Serial input, asynchronous |
| rx_data | output | 8 | Received character, right-aligned |
| rx_valid | output | 1 | One-cycle pulse with a received character |
| rx_par_err | output | 1 | Parity mismatch for this character |
| rx_frm_err | output | 1 | Stop bit sampled low for this character |

## Verification
Transmitter results are due at fixed cycles. The start bit and `tx_busy` appear one cycle after the handshake edge. Each later bit changes on the clock edge of the sixteenth tick of the bit before it, and `tx_ready` follows `cts` after two clock edges. The bench runs a behavioural model that updates on the same edges. It compares `txd`, `tx_busy` and `tx_ready` at every falling edge, half a cycle after the registers settle. The receiver result arrives at the mid-bit sample of the last stop bit. That time depends on where the synchronised edge falls, so the bench checks the data and both flags whenever `rx_valid` is high, against a queue of expected characters. It also reports any pulse that has no expected character queued.

// File: rtl/sfx_pkg.sv
package sfx_pkg;

  // widest character and widest frame (start + data + parity + two stops)
  localparam int DMAX = 8;
  localparam int FMAX = 1 + DMAX + 1 + 2;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_odd;
    logic [1:0] stop;
  } frame_cfg_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_t;

  // reversed length code: 0 -> 8 bits ... 3 -> 5 bits
  function automatic logic [3:0] data_len(input logic [1:0] code);
    return 4'(DMAX - int'(code));
  endfunction

  function automatic logic two_stop(input logic [1:0] code);
    return code == 2'b01;
  endfunction

endpackage

// File: rtl/sfx_sync.sv
module sfx_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= RST_VAL;
      q  <= RST_VAL;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end

endmodule

// File: rtl/sfx_tx.sv
module sfx_tx
  import sfx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  frame_cfg_t      cfg,
  input  logic            go_ok,
  input  logic [DMAX-1:0] data,
  input  logic            valid,
  output logic            ready,
  output logic            txd,
  output logic            busy
);

  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(FMAX + 1);

  logic [CW-1:0]   tcnt;
  logic [FMAX-1:0] sh;
  logic [FMAX-1:0] frame;
  logic [BW-1:0]   left;
  logic [BW-1:0]   total;

  // assemble the whole frame, line level per bit, bit 0 first on the wire
  always_comb begin
    int   n;
    logic par;
    n        = int'(data_len(cfg.len));
    frame    = '1;
    frame[0] = 1'b0;
    par      = cfg.par_odd;
    for (int i = 0; i < DMAX; i++) begin
      if (i < n) begin
        frame[1+i] = data[i];
        par        = par ^ data[i];
      end
    end
    if (cfg.par_en) frame[1+n] = par;
    total = BW'(1 + n + (cfg.par_en ? 1 : 0) + (two_stop(cfg.stop) ? 2 : 1));
  end

  assign ready = !busy && go_ok;
  assign txd   = sh[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      sh   <= '1;
      left <= '0;
      tcnt <= '0;
    end else if (ready && valid) begin
      busy <= 1'b1;
      sh   <= frame;
      left <= total - BW'(1);
      tcnt <= '0;
    end else if (busy && tick) begin
      if (tcnt == CW'(OVS - 1)) begin
        tcnt <= '0;
        if (left == '0) begin
          busy <= 1'b0;
        end else begin
          sh   <= {1'b1, sh[FMAX-1:1]};
          left <= left - BW'(1);
        end
      end else begin
        tcnt <= tcnt + CW'(1);
      end
    end
  end

endmodule

// File: rtl/sfx_rx.sv
module sfx_rx
  import sfx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  frame_cfg_t      cfg,
  input  logic            rxs,
  output logic [DMAX-1:0] data,
  output logic            valid,
  output logic            perr,
  output logic            ferr
);

  localparam int CW  = $clog2(OVS);
  localparam int MID = OVS / 2 - 1;

  rx_state_t       st;
  frame_cfg_t      cq;
  logic [CW-1:0]   cnt;
  logic [3:0]      idx;
  logic [DMAX-1:0] sh;
  logic            acc;
  logic            pe_q;
  logic            fe_q;
  logic            stop2;
  logic            samp;
  logic [3:0]      n;

  assign samp = tick && (cnt == CW'(OVS - 1));
  assign n    = data_len(cq.len);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= RX_IDLE;
      cq    <= '0;
      cnt   <= '0;
      idx   <= '0;
      sh    <= '0;
      acc   <= 1'b0;
      pe_q  <= 1'b0;
      fe_q  <= 1'b0;
      stop2 <= 1'b0;
      data  <= '0;
      valid <= 1'b0;
      perr  <= 1'b0;
      ferr  <= 1'b0;
    end else begin
      valid <= 1'b0;
      case (st)
        RX_IDLE: begin
          if (tick && !rxs) begin
            st   <= RX_START;
            cnt  <= '0;
            cq   <= cfg;
            sh   <= '0;
            acc  <= 1'b0;
            pe_q <= 1'b0;
            fe_q <= 1'b0;
            idx  <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (cnt == CW'(MID)) begin
              cnt <= '0;
              st  <= rxs ? RX_IDLE : RX_DATA;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        end
        RX_DATA: begin
          if (samp) begin
            cnt <= '0;
            sh  <= {rxs, sh[DMAX-1:1]};
            acc <= acc ^ rxs;
            if (idx == n - 4'd1) begin
              idx   <= '0;
              stop2 <= two_stop(cq.stop);
              st    <= cq.par_en ? RX_PAR : RX_STOP;
            end else begin
              idx <= idx + 4'd1;
            end
          end else if (tick) begin
            cnt <= cnt + CW'(1);
          end
        end
        RX_PAR: begin
          if (samp) begin
            cnt  <= '0;
            pe_q <= (acc ^ rxs) != cq.par_odd;
            st   <= RX_STOP;
          end else if (tick) begin
            cnt <= cnt + CW'(1);
          end
        end
        RX_STOP: begin
          if (samp) begin
            cnt <= '0;
            if (stop2) begin
              stop2 <= 1'b0;
              fe_q  <= !rxs;
            end else begin
              valid <= 1'b1;
              data  <= sh >> (DMAX - int'(n));
              perr  <= pe_q;
              ferr  <= fe_q | !rxs;
              st    <= RX_IDLE;
            end
          end else if (tick) begin
            cnt <= cnt + CW'(1);
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/serial_frame_xcvr.sv
module serial_frame_xcvr
  import sfx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       baud_tick,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic [1:0] cfg_stop,
  input  logic       cfg_two_wire,
  input  logic       cts,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic       txd,
  output logic       tx_busy,
  input  logic       rxd,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_par_err,
  output logic       rx_frm_err
);

  frame_cfg_t cfg;
  logic       cts_s;
  logic       rxd_s;

  assign cfg = '{len: cfg_len, par_en: cfg_par_en, par_odd: cfg_par_odd, stop: cfg_stop};

  sfx_sync #(.RST_VAL(1'b0)) u_cts_sync (
    .clk (clk),
    .rst (rst),
    .d   (cts),
    .q   (cts_s)
  );

  sfx_sync #(.RST_VAL(1'b1)) u_rxd_sync (
    .clk (clk),
    .rst (rst),
    .d   (rxd),
    .q   (rxd_s)
  );

  sfx_tx #(.OVS(OVS)) u_tx (
    .clk   (clk),
    .rst   (rst),
    .tick  (baud_tick),
    .cfg   (cfg),
    .go_ok (cfg_two_wire || cts_s),
    .data  (tx_data),
    .valid (tx_valid),
    .ready (tx_ready),
    .txd   (txd),
    .busy  (tx_busy)
  );

  sfx_rx #(.OVS(OVS)) u_rx (
    .clk   (clk),
    .rst   (rst),
    .tick  (baud_tick),
    .cfg   (cfg),
    .rxs   (rxd_s),
    .data  (rx_data),
    .valid (rx_valid),
    .perr  (rx_par_err),
    .ferr  (rx_frm_err)
  );

endmodule

// File: rtl/sfx_chk.sv
module sfx_chk (
  input logic clk,
  input logic rst,
  input logic cfg_two_wire,
  input logic cts,
  input logic tx_valid,
  input logic tx_ready,
  input logic txd,
  input logic tx_busy,
  input logic rx_valid
);

  // R4: no handshake possible while the far end has been holding off
  p_cts_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (!cfg_two_wire && !cts && !$past(cts) && !$past(cts, 2)) |-> !tx_ready);

  // R5: a handshake starts the start bit on the next cycle
  p_start_low_r5: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> (tx_busy && !txd));

  // R5: line idles high
  p_idle_high_r5: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> txd);

  // R6: no new byte taken while a character is on the line
  p_ready_busy_r6: assert property (@(posedge clk) disable iff (rst)
    tx_busy |-> !tx_ready);

  // R6: busy ends after a high stop bit
  p_busy_end_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_busy) |-> $past(txd));

  // R10: each result is a single-cycle pulse
  p_rx_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

endmodule

bind serial_frame_xcvr sfx_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_two_wire (cfg_two_wire),
  .cts          (cts),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready),
  .txd          (txd),
  .tx_busy      (tx_busy),
  .rx_valid     (rx_valid)
);

// File: tb/sim_serial_frame_xcvr.sv
module sim_serial_frame_xcvr;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic [1:0] cfg_len = 2'b00;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic [1:0] cfg_stop = 2'b00;
  logic       cfg_two_wire = 1'b1;
  logic       cts = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready, txd, tx_busy;
  logic       rxd = 1'b1;
  logic [7:0] rx_data;
  logic       rx_valid, rx_par_err, rx_frm_err;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  serial_frame_xcvr u0 (
    .clk(clk), .rst(rst), .baud_tick(baud_tick),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop(cfg_stop), .cfg_two_wire(cfg_two_wire), .cts(cts),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .txd(txd), .tx_busy(tx_busy), .rxd(rxd), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // one oversampling tick every third clock
  int div = 0;
  always @(posedge clk) begin
    if (rst) begin
      div <= 0;
      baud_tick <= 1'b0;
    end else begin
      div <= (div == 2) ? 0 : div + 1;
      baud_tick <= (div == 2);
    end
  end

  typedef bit bq_t[$];

  // line levels of one frame under the current settings (R1 R2 R3)
  function automatic bq_t mk_frame(input logic [7:0] d, input bit bad_par, input bit [1:0] bad_stop);
    bq_t q;
    int n = 8 - int'(cfg_len);
    bit p = cfg_par_odd;
    q.push_back(1'b0);
    for (int i = 0; i < n; i++) begin
      q.push_back(d[i]);
      p ^= d[i];
    end
    if (cfg_par_en) q.push_back(p ^ bad_par);
    q.push_back(!bad_stop[0]);
    if (cfg_stop == 2'b01) q.push_back(!bad_stop[1]);
    return q;
  endfunction

  // transmitter reference model
  bit  m_busy = 1'b0;
  bit  m_txd = 1'b1;
  bit  cd1 = 1'b0, cd2 = 1'b0;
  int  m_cnt = 0;
  bq_t m_q;

  always @(posedge clk) begin
    bit rdy;
    if (rst) begin
      m_busy = 1'b0; m_txd = 1'b1; m_cnt = 0; cd1 = 1'b0; cd2 = 1'b0;
      m_q.delete();
    end else begin
      rdy = !m_busy && (cfg_two_wire || cd2);
      cd2 = cd1;
      cd1 = cts;
      if (rdy && tx_valid) begin
        m_q = mk_frame(tx_data, 1'b0, 2'b00);
        m_txd = m_q.pop_front();
        m_busy = 1'b1;
        m_cnt = 0;
      end else if (m_busy && baud_tick) begin
        if (m_cnt == 15) begin
          m_cnt = 0;
          if (m_q.size() == 0) begin
            m_busy = 1'b0;
            m_txd = 1'b1;
          end else begin
            m_txd = m_q.pop_front();
          end
        end else begin
          m_cnt++;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(txd == m_txd, "R1 R2 R3 R5 txd", txd, m_txd);
      chk(tx_busy == m_busy, "R6 tx_busy", tx_busy, m_busy);
      chk(tx_ready == (!m_busy && (cfg_two_wire || cd2)), "R4 tx_ready",
          tx_ready, !m_busy && (cfg_two_wire || cd2));
    end
  end

  // receiver expectations
  typedef struct { logic [7:0] d; bit pe; bit fe; } rx_exp_t;
  rx_exp_t rq[$];
  rx_exp_t re;

  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      if (rq.size() == 0) begin
        chk(1'b0, "R7 unexpected rx_valid", 1, 0);
      end else begin
        re = rq.pop_front();
        chk(rx_data == re.d, "R10 rx_data", rx_data, re.d);
        chk(rx_par_err == re.pe, "R8 rx_par_err", rx_par_err, re.pe);
        chk(rx_frm_err == re.fe, "R9 rx_frm_err", rx_frm_err, re.fe);
      end
    end
  end

  task automatic set_cfg(input logic [1:0] len, input bit pen, input bit podd, input logic [1:0] stp);
    @(negedge clk); #1;
    cfg_len = len; cfg_par_en = pen; cfg_par_odd = podd; cfg_stop = stp;
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk); #1;
    while (!tx_ready) begin @(negedge clk); #1; end
    tx_data = d; tx_valid = 1'b1;
    @(negedge clk); #1;
    tx_valid = 1'b0;
    while (tx_busy) begin @(negedge clk); #1; end
    repeat (5) @(negedge clk);
  endtask

  task automatic recv(input logic [7:0] d, input bit bad_par, input bit [1:0] bad_stop);
    bq_t q = mk_frame(d, bad_par, bad_stop);
    rx_exp_t e;
    int n = 8 - int'(cfg_len);
    e.d  = d & (8'hFF >> (8 - n));
    e.pe = bad_par && cfg_par_en;
    e.fe = bad_stop[0] || ((cfg_stop == 2'b01) && bad_stop[1]);
    rq.push_back(e);
    @(posedge clk iff baud_tick);
    foreach (q[i]) begin
      #1 rxd = q[i];
      repeat (16) @(posedge clk iff baud_tick);
    end
    #1 rxd = 1'b1;
    repeat (32) @(posedge clk iff baud_tick);
  endtask

  initial begin
    #(200000 * 4);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R5 reset txd", txd, 1);
    chk(tx_busy == 1'b0, "R6 reset busy", tx_busy, 0);
    chk(rx_valid == 1'b0, "R10 reset rx_valid", rx_valid, 0);

    // R1 eight data bits, no parity, one stop
    set_cfg(2'b00, 0, 0, 2'b00);
    send(8'hA5);
    send(8'h3C);
    // R1 R2 seven bits, even parity, top bit must not go out
    set_cfg(2'b01, 1, 0, 2'b00);
    send(8'hD3);
    // R2 R3 six bits, odd parity, two stops
    set_cfg(2'b10, 1, 1, 2'b01);
    send(8'hFF);
    // R1 R3 five bits, reserved stop code acts as one stop
    set_cfg(2'b11, 0, 0, 2'b11);
    send(8'hEA);

    // R4 CTS gate
    set_cfg(2'b00, 0, 0, 2'b00);
    @(negedge clk); #1;
    cfg_two_wire = 1'b0; cts = 1'b0;
    tx_data = 8'h81; tx_valid = 1'b1;
    repeat (40) @(negedge clk);
    chk(tx_busy == 1'b0, "R4 held by cts", tx_busy, 0);
    chk(txd == 1'b1, "R4 line idle while held", txd, 1);
    #1 cts = 1'b1;
    @(negedge clk); #1;
    while (!tx_ready) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    tx_valid = 1'b0;
    chk(tx_busy == 1'b1, "R4 released by cts", tx_busy, 1);
    while (tx_busy) begin @(negedge clk); #1; end
    cts = 1'b0;
    cfg_two_wire = 1'b1;
    send(8'h42);   // R4 two-wire ignores cts

    // receive paths
    set_cfg(2'b00, 0, 0, 2'b00);
    recv(8'h5A, 0, 2'b00);
    recv(8'h00, 0, 2'b00);
    set_cfg(2'b01, 1, 0, 2'b00);
    recv(8'h35, 0, 2'b00);
    recv(8'h35, 1, 2'b00);          // R8
    set_cfg(2'b10, 1, 1, 2'b00);
    recv(8'hC7, 0, 2'b00);
    set_cfg(2'b11, 0, 0, 2'b01);
    recv(8'hFF, 0, 2'b00);          // R10 upper bits zero
    recv(8'h15, 0, 2'b10);          // R9 second stop low
    set_cfg(2'b00, 1, 1, 2'b00);
    recv(8'h96, 0, 2'b01);          // R9 single stop low

    // R7 short start pulse gives no result
    set_cfg(2'b00, 0, 0, 2'b00);
    @(posedge clk iff baud_tick);
    #1 rxd = 1'b0;
    repeat (4) @(posedge clk iff baud_tick);
    #1 rxd = 1'b1;
    repeat (40) @(posedge clk iff baud_tick);
    chk(rq.size() == 0, "R7 queue after glitch", rq.size(), 0);
    recv(8'hE1, 0, 2'b00);

    repeat (20) @(negedge clk);
    chk(rq.size() == 0, "R7 all characters received", rq.size(), 0);
    finish_run();
  end

endmodule